// File: doc/BRIEF.md
# Interrupt Pin Acceptance and End-of-Interrupt Unit

This unit sits between the interrupt input lines of a redirection-table interrupt controller and its delivery logic. Every clock it samples each pin. It uses three settings per entry, taken from the register file: a mask bit, a trigger kind (edge or level) and an 8-bit vector. From these it decides whether a new rising edge turns into a delivery request. Level-triggered entries are held closed by a remote-IRR bit. That bit is set when a delivery is issued and stays set until the processor side sends an end-of-interrupt (EOI).

An EOI arrives as a one-cycle pulse carrying a vector. The lowest-numbered entry holding that vector is reopened by clearing its remote IRR. If that entry is level-triggered, unmasked and its line is still high, the unit re-arms the entry and requests a fresh delivery at once. The remote-IRR bits are driven out so the register file can show them.

Delivery requests leave on a valid/ready stream that carries the binary pin number. Requests that are waiting are kept as one pending bit per pin, and the lowest pending pin is always offered first. While `dlv_ready` is low, the offer stays up and nothing is lost. A new edge on a pin whose request is still waiting merges into that request.

Top module: `irq_accept`

## Requirements
- R1: A rising edge on a pin whose mask bit is 1 produces no delivery and leaves its remote IRR unchanged.
- R2: Each rising edge (low in one sampled cycle, high in the next) on an unmasked pin with trigger kind 0 (edge) produces one delivery request, and its remote IRR stays 0.
- R3: A rising edge on an unmasked pin with trigger kind 1 (level) sets its remote IRR and requests a delivery only if remote IRR was 0. If remote IRR was already 1, nothing happens.
- R4: An EOI applies to the lowest-numbered entry whose 8-bit vector field (bits 8*i+7 to 8*i of `cfg_vector`) equals `eoi_vector`. Higher entries with the same vector are not touched.
- R5: An EOI whose vector matches no entry changes no remote IRR and requests no delivery.
- R6: A matching EOI clears the remote IRR of the selected entry in the following cycle.
- R7: After a matching EOI, if the entry is level-triggered, unmasked and its line is high, remote IRR is set again and one new delivery is requested. If the entry is masked, remote IRR ends up 0 and no delivery is requested.
- R8: When several pins have requests waiting, the lowest pin number is offered first. The others follow in rising pin order in later cycles.
- R9: A request is offered on `dlv_valid` in the cycle after its triggering edge or EOI. `dlv_pin` is the binary pin index. The request is consumed on a clock edge where `dlv_valid` and `dlv_ready` are both 1. While `dlv_ready` is 0, `dlv_valid` stays 1.
- R10: While `rst_n` is low and after it is released, `dlv_valid` is 0 and every remote IRR bit is 0 until an event sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lvl | input | NPINS | Interrupt line levels, one per pin |
| cfg_mask | input | NPINS | Mask bit per entry (1 = masked) |
| cfg_level | input | NPINS | Trigger kind per entry (0 = edge, 1 = level) |
| cfg_vector | input | NPINS*VEC_W | Vector field per entry, entry i in bits VEC_W*i upward |
| eoi_valid | input | 1 | One-cycle EOI pulse |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| dlv_valid | output | 1 | Delivery request offered |
| dlv_ready | input | 1 | Consumer accepts the offered request |
| dlv_pin | output | PIN_W | Pin number of the offered request |
| rirr | output | NPINS | Remote-IRR bit per entry |

## Verification
Two functions can act in the same cycle: an EOI re-delivery on a level pin whose line is still high, and a fresh rising edge on another pin. Both write into the pending set at the same clock edge. The bench provokes this by pulsing the EOI for a high level pin in the same cycle that a lower-numbered edge pin rises. The scoreboard must then see the lower pin first and the re-delivered pin next, and remote IRR of the level pin must still read 1. Back-pressure is also combined with later, lower-numbered arrivals to show that the offered pin can only move downward while the consumer stalls.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_accept_edge.sv
module irq_accept_edge #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] rise
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irq_accept_eoi.sv
module irq_accept_eoi #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8
) (
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic [NPINS*VEC_W-1:0] cfg_vector,
  output logic [NPINS-1:0]       eoi_sel
);
  logic [NPINS-1:0] match;

  for (genvar g = 0; g < NPINS; g++) begin : g_cmp
    assign match[g] = (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);
  end

  // first match wins: lower entries shadow higher ones
  always_comb begin
    logic seen;
    seen    = 1'b0;
    eoi_sel = '0;
    for (int i = 0; i < NPINS; i++) begin
      eoi_sel[i] = eoi_valid & match[i] & ~seen;
      seen       = seen | match[i];
    end
  end
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb #(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] req_set,
  input  logic             dlv_ready,
  output logic             dlv_valid,
  output logic [PIN_W-1:0] dlv_pin
);
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] grant;

  always_comb begin
    dlv_valid = 1'b0;
    dlv_pin   = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        dlv_valid = 1'b1;
        dlv_pin   = PIN_W'(i);
      end
    end
  end

  always_comb begin
    grant = '0;
    if (dlv_valid && dlv_ready) grant[dlv_pin] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~grant) | req_set;
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int VEC_W = 8,
  localparam int PIN_W = idx_width(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       irq_lvl,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS-1:0]       cfg_level,
  input  logic [NPINS*VEC_W-1:0] cfg_vector,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  output logic                   dlv_valid,
  input  logic                   dlv_ready,
  output logic [PIN_W-1:0]       dlv_pin,
  output logic [NPINS-1:0]       rirr
);
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] eoi_sel;
  logic [NPINS-1:0] req_set;
  logic [NPINS-1:0] rirr_q;
  logic [NPINS-1:0] rirr_d;

  irq_accept_edge #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(irq_lvl), .rise(rise)
  );

  irq_accept_eoi #(.NPINS(NPINS), .VEC_W(VEC_W)) u_eoi (
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .cfg_vector(cfg_vector), .eoi_sel(eoi_sel)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic is_lvl, open_edge, open_lvl, reopen;
    assign is_lvl    = (cfg_level[p] == TRIG_LEVEL);
    assign open_edge = rise[p] & ~cfg_mask[p] & ~is_lvl;
    assign open_lvl  = rise[p] & ~cfg_mask[p] & is_lvl & ~rirr_q[p];
    assign reopen    = eoi_sel[p] & is_lvl & ~cfg_mask[p] & irq_lvl[p];
    assign rirr_d[p]  = eoi_sel[p] ? reopen : (rirr_q[p] | open_lvl);
    assign req_set[p] = open_edge | open_lvl | reopen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rirr_q <= '0;
    else        rirr_q <= rirr_d;
  end

  assign rirr = rirr_q;

  irq_accept_arb #(.NPINS(NPINS), .PIN_W(PIN_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .dlv_ready(dlv_ready),
    .dlv_valid(dlv_valid), .dlv_pin(dlv_pin)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] irq_lvl,
  input logic [NPINS-1:0] cfg_mask,
  input logic [NPINS-1:0] cfg_level,
  input logic             eoi_valid,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [PIN_W-1:0] dlv_pin,
  input logic [NPINS-1:0] rirr
);
  // R9: a stalled offer stays up and can only move to a lower pin (R8)
  a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && dlv_pin <= $past(dlv_pin)));

  for (genvar p = 0; p < NPINS; p++) begin : g_p
    // R6: remote IRR falls only as the result of an EOI
    a_r6_fall_needs_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rirr[p]) |-> $past(eoi_valid));

    // R3: remote IRR rises only for an unmasked level entry with its line high (R1)
    a_r3_rise_cond: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rirr[p]) |-> $past(cfg_level[p] && !cfg_mask[p] && irq_lvl[p]));

    // R2: an unmasked edge pin that rises yields an offer next cycle
    a_r2_edge_offer: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_lvl[p]) && !cfg_mask[p] && !cfg_level[p]) |=> dlv_valid);
  end
endmodule

bind irq_accept irq_accept_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .cfg_mask(cfg_mask),
  .cfg_level(cfg_level), .eoi_valid(eoi_valid), .dlv_valid(dlv_valid),
  .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .rirr(rirr)
);

// File: tb/irq_accept_bench.sv
module irq_accept_bench;
  localparam int N = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0, mask = '1, lvl = '0;
  logic [N*VW-1:0] vec;
  logic          eoi_v = 1'b0;
  logic [VW-1:0] eoi_vec = '0;
  logic          ready = 1'b1;
  logic          dv;
  logic [2:0]    dpin;
  logic [N-1:0]  rirr;

  irq_accept u_irq_accept (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq), .cfg_mask(mask), .cfg_level(lvl),
    .cfg_vector(vec), .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
    .dlv_valid(dv), .dlv_ready(ready), .dlv_pin(dpin), .rirr(rirr)
  );

  always #4 clk = ~clk;

  int    checks = 0, errors = 0;
  int    exp_q[$];
  string tag = "R10";

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: every accepted request is compared with the scoreboard
  always @(negedge clk) begin
    int e;
    if (rst_n && dv && ready) begin
      if (exp_q.size() == 0) check(1'b0, tag, dpin, -1);
      else begin
        e = exp_q.pop_front();
        check(dpin == e, tag, dpin, e);
      end
    end
  end

  task automatic drain();
    for (int k = 0; k < 40 && exp_q.size() != 0; k++) step();
    step(3);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_v = 1'b1; eoi_vec = v;
    step();
    eoi_v = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) vec[i*VW +: VW] = VW'(8'h20 + i);
    step(3);
    check(dv == 1'b0, "R10", dv, 0);
    check(rirr == '0, "R10", rirr, 0);
    rst_n = 1'b1;
    step(2);
    check(dv == 1'b0 && rirr == '0, "R10", {dv, rirr}, 0);

    // R1: masked pin rises, nothing happens
    tag = "R1";
    irq[0] = 1'b1; step(3); irq[0] = 1'b0;
    drain();
    check(rirr[0] == 1'b0, "R1", rirr[0], 0);

    // R2: two edges on an unmasked edge pin give two requests
    tag = "R2"; mask[1] = 1'b0;
    exp_q.push_back(1); irq[1] = 1'b1; step(); irq[1] = 1'b0; step();
    exp_q.push_back(1); irq[1] = 1'b1; step(); irq[1] = 1'b0;
    drain();
    check(rirr[1] == 1'b0, "R2", rirr[1], 0);

    // R3: level pin accepted once, second edge blocked
    tag = "R3"; mask[3] = 1'b0; lvl[3] = 1'b1;
    exp_q.push_back(3); irq[3] = 1'b1; step();
    check(rirr[3] == 1'b1, "R3", rirr[3], 1);
    drain();
    irq[3] = 1'b0; step(); irq[3] = 1'b1; step(4);
    drain();
    check(rirr[3] == 1'b1, "R3", rirr[3], 1);

    // R7: EOI while line still high redelivers
    tag = "R7";
    exp_q.push_back(3); eoi(8'h23);
    check(rirr[3] == 1'b1, "R7", rirr[3], 1);
    drain();

    // R6: EOI with line low clears remote IRR, no request
    tag = "R6";
    irq[3] = 1'b0; step();
    eoi(8'h23);
    check(rirr[3] == 1'b0, "R6", rirr[3], 0);
    drain();

    // R5: unmatched EOI
    tag = "R5";
    exp_q.push_back(3); irq[3] = 1'b1; step(); drain();
    eoi(8'h77);
    check(rirr == 8'h08, "R5", rirr, 8'h08);
    drain();

    // R4: shared vector, lowest entry takes the EOI
    tag = "R4"; mask[5] = 1'b0; lvl[5] = 1'b1;
    exp_q.push_back(5); irq[5] = 1'b1; step(); drain();
    vec[5*VW +: VW] = 8'h23;
    irq[3] = 1'b0; step();
    eoi(8'h23);
    check(rirr == 8'h20, "R4", rirr, 8'h20);
    drain();
    vec[5*VW +: VW] = 8'h25;

    // R7: masked entry is not reopened
    tag = "R7"; mask[5] = 1'b1;
    eoi(8'h25);
    check(rirr[5] == 1'b0, "R7", rirr[5], 0);
    drain();
    mask[5] = 1'b0; irq[5] = 1'b0; step();

    // R8: simultaneous edges served lowest first
    tag = "R8"; mask[2] = 1'b0; mask[4] = 1'b0; mask[6] = 1'b0;
    exp_q.push_back(2); exp_q.push_back(4); exp_q.push_back(6);
    irq[6] = 1'b1; irq[2] = 1'b1; irq[4] = 1'b1; step();
    irq[6] = 1'b0; irq[2] = 1'b0; irq[4] = 1'b0;
    drain();

    // R9: back-pressure holds the offer, lower arrival overtakes
    tag = "R9"; ready = 1'b0;
    irq[6] = 1'b1; step(); irq[6] = 1'b0; step(3);
    check(dv == 1'b1 && dpin == 3'd6, "R9", {dv, dpin}, {1'b1, 3'd6});
    irq[2] = 1'b1; step(); irq[2] = 1'b0; step(2);
    check(dv == 1'b1 && dpin == 3'd2, "R9", {dv, dpin}, {1'b1, 3'd2});
    exp_q.push_back(2); exp_q.push_back(6);
    ready = 1'b1;
    drain();

    // R8 with R7: EOI redelivery and a fresh edge in the same cycle
    tag = "R8";
    exp_q.push_back(3); irq[3] = 1'b1; step(); drain();
    exp_q.push_back(1); exp_q.push_back(3);
    irq[1] = 1'b1; eoi_v = 1'b1; eoi_vec = 8'h23; step();
    eoi_v = 1'b0; irq[1] = 1'b0;
    check(rirr[3] == 1'b1, "R7", rirr[3], 1);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule